// File: doc/BRIEF.md
# Saturating Ramp Output Controller

This block produces the code for an output D/A converter from a digitized input sample. An arithmetic stage combines the sample with a host-supplied offset. It can add the offset, subtract it, or pass the sample through unchanged. Sums and differences are clipped at full scale and at zero, so they never wrap.

The result goes into an output register. In the normal mode that register holds its value and reloads on every conversion-complete strobe. Two inputs together keep the register in hold: an external timer-relay signal and a hold bit in the control word. When both are low, the register is released. It then walks one code per step toward full scale or toward zero. The steps are paced by a power-of-two clock divider, which sets the slew rate of the analog output. The walk stops at the limit, and the register stays there until the next reload.

A typical use is a safe ramp-down: the supervising timer drops, and the output glides to zero at a known rate instead of jumping.

Top module: `ramp_out_ctrl`

## Requirements
- R1: A synchronous active-high reset sets `code_o` to 0 on the next rising edge and restarts the divider phase.
- R2: `op_i` selects the arithmetic: 2'b00 passes the sample, 2'b01 gives sample plus offset, 2'b10 gives sample minus offset, and 2'b11 passes the sample.
- R3: Addition above 255 yields 255. Subtraction below 0 yields 0.
- R4: The register is held while `timer_relay_i` OR `hold_bit_i` is high. While held, it loads the arithmetic result on an edge where `sample_stb_i` is high, and otherwise keeps its value.
- R5: While ramping (both hold sources low), `sample_stb_i` and the sample have no effect on `code_o`.
- R6: While ramping, each step adds 1 when `dir_up_i` is 1 and subtracts 1 when it is 0.
- R7: Ramping stops at 255 going up and at 0 going down, never wraps, and stays at the limit until a reload under hold.
- R8: With rate field n (0 to 15), a step happens on every 2^n-th ramping edge, counted from the first edge after release. Any held edge restarts this count.
- R9: `code_o` is a register: a change on the inputs shows on `code_o` after the next rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 8 | Digitized input sample (operand A) |
| sample_stb_i | input | 1 | Conversion-complete strobe for the sample |
| offset_i | input | 8 | Host offset (operand B) |
| op_i | input | 2 | Arithmetic select |
| hold_bit_i | input | 1 | Hold bit from the control word |
| timer_relay_i | input | 1 | External timer-relay hold signal |
| dir_up_i | input | 1 | Ramp direction, 1 = toward full scale |
| rate_i | input | 4 | Divider exponent n, step every 2^n cycles |
| code_o | output | 8 | D/A output code |

## Verification
A wrong prescaler phase shows up as the first ramp step landing one or more cycles too early or too late after release. The bench sees this within 2^n cycles. A counter that wraps shows up at `code_o` as a jump from 255 to 0, or from 0 to 255, on the edge after the limit. A broken hold decode shows up as a change on `code_o` while the timer relay is high, in the very next cycle. Every cycle is compared against an independent model, so a wrong saturation or a wrong op decode shows on the first load that reaches it.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  typedef enum logic [1:0] {
    OP_PASS = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_THRU = 2'b11
  } alu_op_e;
endpackage

// File: rtl/sat_alu.sv
module sat_alu
  import ramp_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);
  logic [W:0] sum;
  logic [W:0] dif;

  always_comb begin
    sum = {1'b0, a} + {1'b0, b};
    dif = {1'b0, a} - {1'b0, b};
    unique case (op)
      OP_ADD:  res = sum[W] ? '1 : sum[W-1:0];
      OP_SUB:  res = dif[W] ? '0 : dif[W-1:0];
      default: res = a;
    endcase
  end
endmodule

// File: rtl/slew_divider.sv
module slew_divider #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int PW = (1 << RATE_W) - 1;

  logic [PW-1:0] presc;
  logic [PW-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PW; i++) begin
      if (i < int'(rate)) mask[i] = 1'b1;
    end
  end

  assign tick = run && ((presc & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) presc <= '0;
    else             presc <= presc + 1'b1;
  end

  // R8
  zero_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (run && rate == '0) |-> tick);
  // R8
  first_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(run) && rate != '0) |-> !tick);
endmodule

// File: rtl/ramp_counter.sv
module ramp_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         up,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (hold) begin
      if (load) cnt <= load_val;
    end else if (tick) begin
      if (up && cnt != MAXV)      cnt <= cnt + 1'b1;
      else if (!up && cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !load) |=> $stable(cnt));
  // R4
  hold_load_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && load) |=> cnt == $past(load_val));
  // R8
  idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !tick) |=> $stable(cnt));
  // R7
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && up && cnt == MAXV) |=> cnt == MAXV);
  // R7
  no_wrap_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !up && cnt == '0) |=> cnt == '0);
  // R6
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && tick) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 ||
                         cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/ramp_out_ctrl.sv
module ramp_out_ctrl
  import ramp_pkg::*;
#(
  parameter int W      = 8,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      sample_i,
  input  logic              sample_stb_i,
  input  logic [W-1:0]      offset_i,
  input  logic [1:0]        op_i,
  input  logic              hold_bit_i,
  input  logic              timer_relay_i,
  input  logic              dir_up_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [W-1:0]      code_o
);
  alu_op_e      op;
  logic [W-1:0] alu_res;
  logic         hold;
  logic         tick;

  assign op   = alu_op_e'(op_i);
  assign hold = timer_relay_i | hold_bit_i;

  sat_alu #(.W(W)) u_alu (
    .op  (op),
    .a   (sample_i),
    .b   (offset_i),
    .res (alu_res)
  );

  slew_divider #(.RATE_W(RATE_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (!hold),
    .rate (rate_i),
    .tick (tick)
  );

  ramp_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold),
    .load     (sample_stb_i),
    .load_val (alu_res),
    .up       (dir_up_i),
    .tick     (tick),
    .cnt      (code_o)
  );

  // R3
  add_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD) |-> alu_res >= sample_i);
  // R3
  sub_ceil_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB) |-> alu_res <= sample_i);
  // R5
  ramp_ignores_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !tick) |=> $stable(code_o));
endmodule

// File: tb/sim_ramp_out_ctrl.sv
`timescale 1ns/1ps
module sim_ramp_out_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sample = '0;
  logic       stb = 1'b0;
  logic [7:0] offset = '0;
  logic [1:0] op = 2'b00;
  logic       hbit = 1'b1;
  logic       trs = 1'b0;
  logic       up = 1'b1;
  logic [3:0] rate = '0;
  logic [7:0] code;

  always #2 clk = ~clk;

  ramp_out_ctrl u0 (
    .clk(clk), .rst(rst), .sample_i(sample), .sample_stb_i(stb),
    .offset_i(offset), .op_i(op), .hold_bit_i(hbit), .timer_relay_i(trs),
    .dir_up_i(up), .rate_i(rate), .code_o(code)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0]  m_code = '0;
  logic [14:0] m_pre  = '0;

  function automatic logic [7:0] ref_alu(logic [1:0] o, logic [7:0] a, logic [7:0] b);
    int s;
    case (o)
      2'b01: begin s = int'(a) + int'(b); return (s > 255) ? 8'd255 : 8'(s); end
      2'b10: begin s = int'(a) - int'(b); return (s < 0) ? 8'd0 : 8'(s); end
      default: return a;
    endcase
  endfunction

  // driver: model the edge to come, queue the expectation, then let it happen
  task automatic cyc(string tag);
    logic [14:0] mk;
    mk = 15'h7fff >> (15 - int'(rate));
    if (rst) begin
      m_code = '0; m_pre = '0;
    end else if (trs || hbit) begin
      m_pre = '0;
      if (stb) m_code = ref_alu(op, sample, offset);
    end else begin
      if ((m_pre & mk) == mk) begin
        if (up && m_code != 8'd255) m_code = m_code + 8'd1;
        else if (!up && m_code != 8'd0) m_code = m_code - 8'd1;
      end
      m_pre = m_pre + 15'd1;
    end
    exp_q.push_back(m_code);
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  task automatic cycn(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (code !== e) begin
        errors++;
        $display("FAIL %s: code_o=%0d expected %0d", t, code, e);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected <= %0d", wd, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cycn(2, "R1 reset value");
    rst = 1'b0;
    // R2 pass, R9 one-edge latency
    sample = 8'd77; stb = 1'b1; op = 2'b00;
    cyc("R2 pass / R9");
    stb = 1'b0; sample = 8'd5;
    cycn(2, "R4 hold keeps without strobe");
    stb = 1'b1; op = 2'b01; sample = 8'd30; offset = 8'd20;
    cyc("R2 add");
    sample = 8'd200; offset = 8'd100;
    cyc("R3 add saturates 255");
    op = 2'b10; sample = 8'd50; offset = 8'd20;
    cyc("R2 subtract");
    sample = 8'd20; offset = 8'd50;
    cyc("R3 subtract saturates 0");
    op = 2'b11; sample = 8'd99;
    cyc("R2 code 11 passes");
    // ramp up at full rate to the top
    op = 2'b00; sample = 8'd250;
    cyc("R4 load");
    stb = 1'b0; hbit = 1'b0; up = 1'b1; rate = 4'd0;
    cycn(8, "R6 R7 ramp up stops at 255");
    stb = 1'b1; sample = 8'd3;
    cycn(3, "R5 strobe ignored while ramping");
    stb = 1'b0;
    trs = 1'b1;
    cycn(3, "R4 timer relay holds");
    stb = 1'b1; sample = 8'd12;
    cyc("R4 load under timer hold");
    stb = 1'b0;
    trs = 1'b0; up = 1'b0; rate = 4'd2;
    cycn(60, "R8 R7 ramp down by 4-cycle steps to 0");
    hbit = 1'b1; stb = 1'b1; sample = 8'd40;
    cyc("R7 reload after limit");
    stb = 1'b0; hbit = 1'b0; up = 1'b1; rate = 4'd1;
    cycn(7, "R8 ramp every second edge");
    trs = 1'b1;
    cycn(2, "R4 timer hold mid-ramp");
    trs = 1'b0; rate = 4'd3;
    cycn(20, "R8 phase restarts after hold");
    rst = 1'b1;
    cyc("R1 reset mid-ramp");
    rst = 1'b0; hbit = 1'b1;
    cycn(2, "R1 stays 0 under hold");
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule